// File: doc/BRIEF.md
# Receive-path latched error status with maskable interrupt

This block collects single-cycle condition pulses from a receive datapath and holds each one in its own status bit. The sources are I and Q overflow in a gain/phase/offset correction stage, I and Q converter overflow, overflow in two filter accumulators (63-tap and 49-tap), and a marker that fires on each Q-phase sample word. The marker bit lets a host realign its sample stream, so it is not an error. A host reads the whole word at once. Each read clears the held bits, except a bit whose source pulses in the same cycle as the read.

A companion mask input selects which held bits may pull the active-low interrupt line. Bit 0 of the word is a summary flag. It is high while any held bit is also enabled by its mask. The host bus and the real datapath sources are outside this block and appear as plain ports. The status word is read-only. In the host's 7-bit register space it sits at offset 0x20, and the decoding of that offset is done outside this block.

Top module: `err_stat_reg`

## Requirements
- R1: After reset every status bit reads 0 and `irq_n` is 1.
- R2: A pulse on `src_evt[k]` sets status bit k+1 at the next clock edge. With the default 7 sources the bit positions are: 7 Q correction-stage overflow, 6 I correction-stage overflow, 5 converter Q overflow, 4 converter I overflow, 3 63-tap accumulator overflow, 2 49-tap accumulator overflow, 1 Q-phase sample marker.
- R3: A set status bit stays set while no read occurs, even after its source pulse has ended.
- R4: A cycle with `rd_stb` high clears every status bit whose source is low in that cycle. A bit whose source is high in the read cycle is set after the read.
- R5: During the cycle in which `rd_stb` is high, `rd_data` shows the status as it was before the read clears it.
- R6: `rd_data[0]` is 1 exactly when some status bit k+1 is set and `mask_i[k]` is 1. A masked bit still latches and reads back.
- R7: `irq_n` goes low one cycle after an unmasked status bit is set. It returns high one cycle after no unmasked bit remains set.
- R8: A change on `mask_i` does not alter any latched status bit. It only changes `rd_data[0]` and, one cycle later, `irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | N_SRC | Single-cycle condition pulses; bit k feeds status bit k+1 |
| mask_i | input | N_SRC | Enable per source; 1 lets the bit reach the interrupt |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_data | output | N_SRC+1 | Status word; bit 0 is the unmasked-activity summary |
| irq_n | output | 1 | Registered interrupt, active low |

## Verification
The bench builds the block with the default of seven sources, which gives the full 8-bit word with its real bit layout. At this width one table can drive every source at once and still check each bit position on its own. The steps cover a read that lands on a source pulse, a read that swaps old bits for new ones, a mask that hides set bits, and a mask that exposes them. Each step also checks the value returned during the read cycle. Directed steps then check the reset state before and after activity.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;
   // Status bit positions for the default seven-source layout
   localparam int unsigned BIT_SUMMARY  = 0;
   localparam int unsigned BIT_QPHASE   = 1;
   localparam int unsigned BIT_ACC49_OF = 2;
   localparam int unsigned BIT_ACC63_OF = 3;
   localparam int unsigned BIT_ADCI_OF  = 4;
   localparam int unsigned BIT_ADCQ_OF  = 5;
   localparam int unsigned BIT_CORI_OF  = 6;
   localparam int unsigned BIT_CORQ_OF  = 7;
   localparam int unsigned DEF_N_SRC    = 7;
endpackage

// File: rtl/err_sticky_bit.sv
module err_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // Set wins over clear, so a pulse in the read cycle survives the read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/err_irq_drive.sv
module err_irq_drive #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] stat_i,
   input  logic [N-1:0] en_i,
   output logic         any_o,
   output logic         irq_n_o
);
   assign any_o = |(stat_i & en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_o <= 1'b1;
      else        irq_n_o <= ~any_o;
   end
endmodule

// File: rtl/err_stat_reg.sv
module err_stat_reg
   import err_stat_pkg::*;
#(
   parameter int unsigned N_SRC = DEF_N_SRC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_evt,
   input  logic [N_SRC-1:0] mask_i,
   input  logic             rd_stb,
   output logic [N_SRC:0]   rd_data,
   output logic             irq_n
);
   localparam int unsigned W = N_SRC + 1;

   generate
      if (N_SRC < 1 || N_SRC > 31) begin : g_bad_n
         $error("err_stat_reg: N_SRC must lie in 1..31");
      end
   endgenerate

   logic [N_SRC-1:0] stat;
   logic             any_en;

   generate
      for (genvar k = 0; k < N_SRC; k++) begin : g_bit
         err_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (src_evt[k]),
            .clr_i (rd_stb),
            .q_o   (stat[k])
         );

         a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[k] |=> rd_data[k+1]);
         a_r3_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[k+1] && !rd_stb) |=> rd_data[k+1]);
         a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_stb && !src_evt[k]) |=> !rd_data[k+1]);
      end
   endgenerate

   err_irq_drive #(.N(N_SRC)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_i  (stat),
      .en_i    (mask_i),
      .any_o   (any_en),
      .irq_n_o (irq_n)
   );

   assign rd_data = {stat, any_en};

   a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_i == '0) |-> !rd_data[0]);
   a_r7_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[0] |=> !irq_n);
   a_r7_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[0] |=> irq_n);
   a_r8_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && src_evt == '0) |=> rd_data[W-1:1] == $past(rd_data[W-1:1]));
endmodule

// File: tb/test_err_stat_reg.sv
module test_err_stat_reg;
   localparam int N = 7;
   localparam int NV = 12;
   // {evt[6:0], mask[6:0], rd, exp_stat[6:0], exp_irq_n}
   localparam logic [22:0] VEC [NV] = '{
      {7'b0000001, 7'b0000000, 1'b0, 7'b0000001, 1'b1}, // R2 marker set, R6 masked
      {7'b0000000, 7'b0000000, 1'b0, 7'b0000001, 1'b1}, // R3 hold
      {7'b0000000, 7'b0000001, 1'b0, 7'b0000001, 1'b0}, // R8 unmask -> R7
      {7'b0000000, 7'b0000001, 1'b1, 7'b0000000, 1'b0}, // R4 clear, R5
      {7'b0000000, 7'b0000001, 1'b0, 7'b0000000, 1'b1}, // R7 release
      {7'b1000000, 7'b1111111, 1'b0, 7'b1000000, 1'b1}, // R2 bit7
      {7'b1000000, 7'b1111111, 1'b1, 7'b1000000, 1'b0}, // R4 pending wins
      {7'b0010100, 7'b1111111, 1'b1, 7'b0010100, 1'b0}, // R4 swap
      {7'b0000000, 7'b0000000, 1'b0, 7'b0010100, 1'b1}, // R8 mask all
      {7'b0000000, 7'b0000000, 1'b1, 7'b0000000, 1'b1}, // R4
      {7'b1111111, 7'b0000100, 1'b0, 7'b1111111, 1'b1}, // R2 all
      {7'b0000000, 7'b0000100, 1'b0, 7'b1111111, 1'b0}  // R6/R7 one enabled
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src_evt = '0;
   logic [N-1:0] mask_i = '0;
   logic         rd_stb = 1'b0;
   logic [N:0]   rd_data;
   logic         irq_n;
   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   err_stat_reg #(.N_SRC(N)) i_err_stat_reg (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .mask_i(mask_i),
      .rd_stb(rd_stb), .rd_data(rd_data), .irq_n(irq_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin
      logic [N-1:0] prev;
      prev = '0;
      #13;
      chk("R1 status", 32'(rd_data), 32'h0);
      chk("R1 irq_n", 32'(irq_n), 32'h1);
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         src_evt = VEC[i][22:16];
         mask_i  = VEC[i][15:9];
         rd_stb  = VEC[i][8];
         #1;
         if (rd_stb) chk("R5 pre-clear", 32'(rd_data), 32'({prev, |(prev & mask_i)}));
         @(posedge clk); #2;
         chk("R2/R3/R4 status", 32'(rd_data[N:1]), 32'(VEC[i][7:1]));
         chk("R6 summary", 32'(rd_data[0]), 32'(|(VEC[i][7:1] & mask_i)));
         chk("R7 irq_n", 32'(irq_n), 32'(VEC[i][0]));
         prev = VEC[i][7:1];
      end
      @(negedge clk); src_evt = '0; rd_stb = 1'b0;
      rst_n = 1'b0; #1;
      chk("R1 status after reset", 32'(rd_data), 32'h0);
      chk("R1 irq_n after reset", 32'(irq_n), 32'h1);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin repeat (2000) @(posedge clk); checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done"); end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule